// File: doc/BRIEF.md
# Reorder Buffer with In-Order Retirement

This block holds speculative micro-op results in a 16-slot circular queue between the rename stage and architectural retirement. Each renamed micro-op takes one slot at the tail and gets the slot index back as its tag. Execution units return results or faults by tag in any order. The buffer retires slots only from the head, in program order. Each retired slot sends its destination register number and result to the architectural register file.

A faulting slot that reaches the head is never retired. The block raises a handler request that names the slot and holds it until the pipeline is flushed. The flush empties the buffer in one cycle. Execution units can read finished results by tag through a set of read ports. Several live slots may target the same architectural register, and each one retires separately.

Allocation and retirement are valid/ready streams. An allocation takes place on a cycle where `alloc_valid` and `alloc_ready` are both high. `alloc_ready` falls while the buffer is full, unless a retirement happens in the same cycle. It is always low during a flush. A retirement takes place when `commit_valid` and `commit_ready` are both high. While `commit_ready` is low, the presented destination and value stay unchanged. Write-back, flush and fault are plain control pins with no handshake.

Top module: `reorder_buffer`

## Requirements
- R1: After reset the buffer is empty: `alloc_ready` is 1, `commit_valid` is 0, `fault_req` is 0, and the first tag handed out is 0.
- R2: Each accepted allocation takes the tail slot, and `alloc_tag` shows that slot's index. Successive tags step by one, modulo 16.
- R3: A write-back to an occupied slot that has no result yet stores the value and fault bit and marks the slot done, in any order. A write-back to a free slot, or to a slot that is already done, is ignored.
- R4: With all 16 slots occupied, `alloc_ready` is 0 unless a retirement fires in the same cycle. In that case both the allocation and the retirement happen, and the new tag equals the index of the retiring slot.
- R5: `commit_valid` is 1 only while the head slot is occupied, done and fault-free, and at most one slot retires per cycle. Retirement is strictly in allocation order. While `commit_ready` is 0, `commit_dest` and `commit_value` hold steady.
- R6: A done head slot that carries a fault never retires. One cycle after it becomes the done head, `fault_req` rises and `fault_tag` gives its index.
- R7: `fault_req` stays high until a flush.
- R8: A flush pulse frees every slot, moves the head onto the tail and clears `fault_req`, all in one cycle. The next tag is the old tail index. Allocation is refused during the flush cycle.
- R9: For each read port, `rd_ready` is 1 and `rd_value` is the stored result when the addressed slot is occupied, done and fault-free. Otherwise `rd_ready` is 0.
- R10: Several occupied slots may name the same destination register, and each retires with its own value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| alloc_valid | input | 1 | Allocation request |
| alloc_ready | output | 1 | Slot available for allocation this cycle |
| alloc_dest | input | 5 | Destination register of the allocating micro-op |
| alloc_tag | output | 4 | Index of the slot being allocated |
| wb_valid | input | 1 | Write-back strobe |
| wb_tag | input | 4 | Slot addressed by the write-back |
| wb_value | input | 32 | Result value |
| wb_fault | input | 1 | Result is a fault |
| commit_valid | output | 1 | Head slot ready to retire |
| commit_ready | input | 1 | Register file accepts the retirement |
| commit_dest | output | 5 | Destination register of the retiring slot |
| commit_value | output | 32 | Value of the retiring slot |
| fault_req | output | 1 | Handler request, held until flush |
| fault_tag | output | 4 | Index of the faulting head slot |
| flush | input | 1 | Discard all slots |
| rd_tag | input | 2x4 | Slot index per read port |
| rd_ready | output | 2 | Read port holds a finished result |
| rd_value | output | 2x32 | Result per read port |

## Verification
The risky overlap is an allocation and a retirement in the same cycle while all 16 slots are full. The write slot then equals the head slot that is being freed. The bench fills the buffer with the retire side stalled and completes every slot. It then raises `commit_ready` and `alloc_valid` on the same cycle, and checks that `alloc_ready` is high and that the offered tag equals the head index. The scoreboard then checks that the old head value retires first and the new slot's value retires last, after all of the others.

// File: rtl/rob_pkg.sv
package rob_pkg;
  localparam int ROB_DEPTH_DEF = 16;
  localparam int ROB_REG_W_DEF = 5;
  localparam int ROB_DATA_W_DEF = 32;
  localparam int ROB_RD_PORTS_DEF = 2;

  typedef struct packed {
    logic live;
    logic done;
    logic bad;
  } rob_flags_t;
endpackage

// File: rtl/rob_ptrs.sv
module rob_ptrs #(
  parameter int DEPTH = 16,
  localparam int IDX_W = $clog2(DEPTH),
  localparam int PTR_W = IDX_W + 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             push,
  input  logic             pop,
  input  logic             flush,
  output logic [PTR_W-1:0] head,
  output logic [PTR_W-1:0] tail,
  output logic             full
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      head <= '0;
      tail <= '0;
    end else if (flush) begin
      head <= tail;
    end else begin
      if (push) tail <= tail + PTR_W'(1);
      if (pop)  head <= head + PTR_W'(1);
    end
  end

  assign full = (head[IDX_W-1:0] == tail[IDX_W-1:0]) && (head[IDX_W] != tail[IDX_W]);
endmodule

// File: rtl/rob_store.sv
module rob_store
  import rob_pkg::*;
#(
  parameter int DEPTH = 16,
  parameter int REG_W = 5,
  parameter int DATA_W = 32,
  parameter int NUM_RD = 2,
  localparam int IDX_W = $clog2(DEPTH)
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          flush,
  input  logic                          alloc_fire,
  input  logic [IDX_W-1:0]              alloc_idx,
  input  logic [REG_W-1:0]              alloc_dest,
  input  logic                          wb_valid,
  input  logic [IDX_W-1:0]              wb_idx,
  input  logic [DATA_W-1:0]             wb_value,
  input  logic                          wb_fault,
  input  logic                          retire,
  input  logic [IDX_W-1:0]              head_idx,
  output rob_flags_t                    head_flags,
  output logic [REG_W-1:0]              head_dest,
  output logic [DATA_W-1:0]             head_value,
  input  logic [NUM_RD-1:0][IDX_W-1:0]  rd_idx,
  output logic [NUM_RD-1:0]             rd_ready,
  output logic [NUM_RD-1:0][DATA_W-1:0] rd_value
);
  rob_flags_t        flags [DEPTH];
  logic [REG_W-1:0]  dests [DEPTH];
  logic [DATA_W-1:0] vals  [DEPTH];

  for (genvar s = 0; s < DEPTH; s++) begin : g_slot
    logic take, fill, drop;
    assign take = alloc_fire && (alloc_idx == IDX_W'(s));
    assign fill = wb_valid && (wb_idx == IDX_W'(s)) && flags[s].live && !flags[s].done;
    assign drop = retire && (head_idx == IDX_W'(s));

    always_ff @(posedge clk) begin
      if (!rst_n || flush) begin
        flags[s] <= '0;
      end else begin
        if (drop) flags[s].live <= 1'b0;
        if (fill) begin
          flags[s].done <= 1'b1;
          flags[s].bad  <= wb_fault;
        end
        if (take) flags[s] <= '{live: 1'b1, done: 1'b0, bad: 1'b0};
      end
    end

    always_ff @(posedge clk) begin
      if (take) dests[s] <= alloc_dest;
      if (fill) vals[s]  <= wb_value;
    end
  end

  assign head_flags = flags[head_idx];
  assign head_dest  = dests[head_idx];
  assign head_value = vals[head_idx];

  for (genvar p = 0; p < NUM_RD; p++) begin : g_rd
    assign rd_ready[p] = flags[rd_idx[p]].live && flags[rd_idx[p]].done && !flags[rd_idx[p]].bad;
    assign rd_value[p] = vals[rd_idx[p]];
  end
endmodule

// File: rtl/rob_retire.sv
module rob_retire
  import rob_pkg::*;
#(
  parameter int DEPTH = 16,
  localparam int IDX_W = $clog2(DEPTH)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             flush,
  input  rob_flags_t       head_flags,
  input  logic [IDX_W-1:0] head_idx,
  input  logic             commit_ready,
  output logic             commit_valid,
  output logic             retire,
  output logic             fault_req,
  output logic [IDX_W-1:0] fault_tag
);
  logic head_done;
  assign head_done    = head_flags.live && head_flags.done;
  assign commit_valid = head_done && !head_flags.bad && !flush;
  assign retire       = commit_valid && commit_ready;

  always_ff @(posedge clk) begin
    if (!rst_n || flush) begin
      fault_req <= 1'b0;
      fault_tag <= '0;
    end else if (head_done && head_flags.bad && !fault_req) begin
      fault_req <= 1'b1;
      fault_tag <= head_idx;
    end
  end
endmodule

// File: rtl/reorder_buffer.sv
module reorder_buffer
  import rob_pkg::*;
#(
  parameter int DEPTH = ROB_DEPTH_DEF,
  parameter int REG_W = ROB_REG_W_DEF,
  parameter int DATA_W = ROB_DATA_W_DEF,
  parameter int NUM_RD = ROB_RD_PORTS_DEF,
  localparam int IDX_W = $clog2(DEPTH),
  localparam int PTR_W = IDX_W + 1
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          alloc_valid,
  output logic                          alloc_ready,
  input  logic [REG_W-1:0]              alloc_dest,
  output logic [IDX_W-1:0]              alloc_tag,
  input  logic                          wb_valid,
  input  logic [IDX_W-1:0]              wb_tag,
  input  logic [DATA_W-1:0]             wb_value,
  input  logic                          wb_fault,
  output logic                          commit_valid,
  input  logic                          commit_ready,
  output logic [REG_W-1:0]              commit_dest,
  output logic [DATA_W-1:0]             commit_value,
  output logic                          fault_req,
  output logic [IDX_W-1:0]              fault_tag,
  input  logic                          flush,
  input  logic [NUM_RD-1:0][IDX_W-1:0]  rd_tag,
  output logic [NUM_RD-1:0]             rd_ready,
  output logic [NUM_RD-1:0][DATA_W-1:0] rd_value
);
  logic [PTR_W-1:0] head, tail;
  logic             full, retire, alloc_fire;
  rob_flags_t       head_flags;

  assign alloc_ready = !flush && (!full || retire);
  assign alloc_fire  = alloc_valid && alloc_ready;
  assign alloc_tag   = tail[IDX_W-1:0];

  rob_ptrs #(.DEPTH(DEPTH)) ptrs_i (
    .clk(clk), .rst_n(rst_n), .push(alloc_fire), .pop(retire), .flush(flush),
    .head(head), .tail(tail), .full(full)
  );

  rob_store #(.DEPTH(DEPTH), .REG_W(REG_W), .DATA_W(DATA_W), .NUM_RD(NUM_RD)) store_i (
    .clk(clk), .rst_n(rst_n), .flush(flush),
    .alloc_fire(alloc_fire), .alloc_idx(tail[IDX_W-1:0]), .alloc_dest(alloc_dest),
    .wb_valid(wb_valid), .wb_idx(wb_tag), .wb_value(wb_value), .wb_fault(wb_fault),
    .retire(retire), .head_idx(head[IDX_W-1:0]),
    .head_flags(head_flags), .head_dest(commit_dest), .head_value(commit_value),
    .rd_idx(rd_tag), .rd_ready(rd_ready), .rd_value(rd_value)
  );

  rob_retire #(.DEPTH(DEPTH)) retire_i (
    .clk(clk), .rst_n(rst_n), .flush(flush),
    .head_flags(head_flags), .head_idx(head[IDX_W-1:0]),
    .commit_ready(commit_ready), .commit_valid(commit_valid), .retire(retire),
    .fault_req(fault_req), .fault_tag(fault_tag)
  );
endmodule

// File: rtl/rob_checker.sv
module rob_checker #(
  parameter int DEPTH = 16,
  parameter int REG_W = 5,
  parameter int DATA_W = 32,
  localparam int IDX_W = $clog2(DEPTH)
) (
  input logic              clk,
  input logic              rst_n,
  input logic              alloc_valid,
  input logic              alloc_ready,
  input logic [IDX_W-1:0]  alloc_tag,
  input logic              commit_valid,
  input logic              commit_ready,
  input logic [REG_W-1:0]  commit_dest,
  input logic [DATA_W-1:0] commit_value,
  input logic              fault_req,
  input logic              flush
);
  logic [IDX_W:0] occ;
  logic a_fire, c_fire;
  assign a_fire = alloc_valid && alloc_ready;
  assign c_fire = commit_valid && commit_ready;

  always_ff @(posedge clk) begin
    if (!rst_n || flush) occ <= '0;
    else occ <= occ + (IDX_W+1)'(a_fire) - (IDX_W+1)'(c_fire);
  end

  assert_tag_step_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (a_fire && !flush) |=> (alloc_tag == $past(alloc_tag) + IDX_W'(1)));

  assert_full_stall_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (occ == (IDX_W+1)'(DEPTH) && !c_fire) |-> !alloc_ready);

  assert_no_overfill_R4: assert property (@(posedge clk) disable iff (!rst_n)
    occ <= (IDX_W+1)'(DEPTH));

  assert_empty_idle_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (occ == '0) |-> !commit_valid);

  assert_commit_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (commit_valid && !commit_ready && !flush) |=>
      (commit_valid && $stable(commit_dest) && $stable(commit_value)));

  assert_fault_blocks_R6: assert property (@(posedge clk) disable iff (!rst_n)
    fault_req |-> !commit_valid);

  assert_fault_sticky_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (fault_req && !flush) |=> fault_req);

  assert_flush_clears_R8: assert property (@(posedge clk) disable iff (!rst_n)
    flush |=> (!fault_req && !commit_valid && (alloc_ready || flush)));
endmodule

bind reorder_buffer rob_checker #(.DEPTH(DEPTH), .REG_W(REG_W), .DATA_W(DATA_W)) chk_i (
  .clk(clk), .rst_n(rst_n), .alloc_valid(alloc_valid), .alloc_ready(alloc_ready),
  .alloc_tag(alloc_tag), .commit_valid(commit_valid), .commit_ready(commit_ready),
  .commit_dest(commit_dest), .commit_value(commit_value), .fault_req(fault_req),
  .flush(flush)
);

// File: tb/reorder_buffer_tb_top.sv
`timescale 1ns/1ps
module reorder_buffer_tb_top;
  localparam int DEPTH = 16;
  localparam int IW = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic alloc_valid = 1'b0, alloc_ready;
  logic [4:0] alloc_dest = '0;
  logic [IW-1:0] alloc_tag;
  logic wb_valid = 1'b0, wb_fault = 1'b0;
  logic [IW-1:0] wb_tag = '0;
  logic [31:0] wb_value = '0;
  logic commit_valid, commit_ready = 1'b1;
  logic [4:0] commit_dest;
  logic [31:0] commit_value;
  logic fault_req;
  logic [IW-1:0] fault_tag;
  logic flush = 1'b0;
  logic [1:0][IW-1:0] rd_tag = '0;
  logic [1:0] rd_ready;
  logic [1:0][31:0] rd_value;

  always #2 clk = ~clk;

  reorder_buffer dut_i (
    .clk(clk), .rst_n(rst_n), .alloc_valid(alloc_valid), .alloc_ready(alloc_ready),
    .alloc_dest(alloc_dest), .alloc_tag(alloc_tag), .wb_valid(wb_valid), .wb_tag(wb_tag),
    .wb_value(wb_value), .wb_fault(wb_fault), .commit_valid(commit_valid),
    .commit_ready(commit_ready), .commit_dest(commit_dest), .commit_value(commit_value),
    .fault_req(fault_req), .fault_tag(fault_tag), .flush(flush), .rd_tag(rd_tag),
    .rd_ready(rd_ready), .rd_value(rd_value)
  );

  int n_chk = 0, n_bad = 0;
  bit finished = 1'b0;
  logic [36:0] sb [$];
  logic [31:0] pend_val [DEPTH];
  logic [IW-1:0] exp_tail = '0;

  task automatic check(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // Scoreboard monitor: every retirement is compared with the oldest expected item.
  initial begin
    forever begin
      @(negedge clk);
      #1;
      if (rst_n && commit_valid && commit_ready) begin
        if (sb.size() == 0) begin
          check(1'b0, "R5 unexpected retirement", {27'd0, commit_dest, commit_value}, 64'd0);
        end else begin
          logic [36:0] e;
          e = sb.pop_front();
          check({commit_dest, commit_value} == e, "R5/R10 retire order",
                {27'd0, commit_dest, commit_value}, {27'd0, e});
        end
      end
    end
  end

  task automatic do_alloc(input logic [4:0] d, input logic [31:0] v, input bit expect_retire);
    @(negedge clk);
    alloc_valid = 1'b1;
    alloc_dest = d;
    #1;
    check(alloc_ready, "R2 alloc_ready", {63'd0, alloc_ready}, 64'd1);
    check(alloc_tag == exp_tail, "R2 tag", {60'd0, alloc_tag}, {60'd0, exp_tail});
    pend_val[alloc_tag] = v;
    if (expect_retire) sb.push_back({d, v});
    exp_tail = exp_tail + 1'b1;
    @(posedge clk);
    #1;
    alloc_valid = 1'b0;
  endtask

  task automatic do_wb(input logic [IW-1:0] t, input bit f, input logic [31:0] v);
    @(negedge clk);
    wb_valid = 1'b1;
    wb_tag = t;
    wb_fault = f;
    wb_value = v;
    @(posedge clk);
    #1;
    wb_valid = 1'b0;
    wb_fault = 1'b0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    #1;
    // R1 reset state
    check(alloc_ready == 1'b1, "R1 alloc_ready", {63'd0, alloc_ready}, 64'd1);
    check(commit_valid == 1'b0, "R1 commit_valid", {63'd0, commit_valid}, 64'd0);
    check(fault_req == 1'b0, "R1 fault_req", {63'd0, fault_req}, 64'd0);
    check(alloc_tag == '0, "R1 first tag", {60'd0, alloc_tag}, 64'd0);

    // Out-of-order completion, same destination twice (R10)
    do_alloc(5'd1, 32'hA000_0000, 1'b1);
    do_alloc(5'd2, 32'hA000_0001, 1'b1);
    do_alloc(5'd3, 32'hA000_0002, 1'b1);
    do_alloc(5'd1, 32'hA000_0003, 1'b1);
    do_wb(4'd3, 1'b0, pend_val[3]);
    do_wb(4'd1, 1'b0, pend_val[1]);
    @(negedge clk);
    rd_tag[0] = 4'd1;
    rd_tag[1] = 4'd0;
    #1;
    check(commit_valid == 1'b0, "R5 head not done", {63'd0, commit_valid}, 64'd0);
    check(rd_ready[0] == 1'b1, "R9 read done slot", {63'd0, rd_ready[0]}, 64'd1);
    check(rd_value[0] == pend_val[1], "R9 read value", {32'd0, rd_value[0]}, {32'd0, pend_val[1]});
    check(rd_ready[1] == 1'b0, "R9 read pending slot", {63'd0, rd_ready[1]}, 64'd0);
    do_wb(4'd1, 1'b0, 32'hDEAD_BEEF);
    #1;
    check(rd_value[0] == pend_val[1], "R3 rewrite ignored", {32'd0, rd_value[0]}, {32'd0, pend_val[1]});
    do_wb(4'd0, 1'b0, pend_val[0]);
    do_wb(4'd2, 1'b0, pend_val[2]);
    repeat (6) @(negedge clk);
    check(sb.size() == 0, "R5 first batch retired", 64'(sb.size()), 64'd0);

    // Fill to full with retirement stalled (R4)
    commit_ready = 1'b0;
    for (int i = 0; i < DEPTH; i++) do_alloc(5'(i + 4), 32'hB000_0000 + i, 1'b1);
    #1;
    check(alloc_ready == 1'b0, "R4 full stall", {63'd0, alloc_ready}, 64'd0);
    for (int i = 0; i < DEPTH; i++) begin
      logic [IW-1:0] t;
      t = IW'(3 - i);
      do_wb(t, 1'b0, pend_val[t]);
    end
    @(negedge clk);
    #1;
    check(commit_valid == 1'b1, "R5 head ready", {63'd0, commit_valid}, 64'd1);
    check(alloc_ready == 1'b0, "R4 full, no retire", {63'd0, alloc_ready}, 64'd0);
    begin
      logic [31:0] held;
      held = commit_value;
      repeat (2) @(negedge clk);
      #1;
      check(commit_value == held, "R5 hold under backpressure", {32'd0, commit_value}, {32'd0, held});
    end
    // Same-cycle allocate and retire on a full buffer
    @(negedge clk);
    commit_ready = 1'b1;
    alloc_valid = 1'b1;
    alloc_dest = 5'd30;
    #1;
    check(alloc_ready == 1'b1, "R4 alloc with retire", {63'd0, alloc_ready}, 64'd1);
    check(alloc_tag == 4'd4, "R4 tag equals head", {60'd0, alloc_tag}, 64'd4);
    sb.push_back({5'd30, 32'hC0DE_0004});
    @(posedge clk);
    #1;
    alloc_valid = 1'b0;
    pend_val[4] = 32'hC0DE_0004;
    exp_tail = exp_tail + 1'b1;
    repeat (18) @(negedge clk);
    check(sb.size() == 1, "R5 stops at undone slot", 64'(sb.size()), 64'd1);
    do_wb(4'd4, 1'b0, pend_val[4]);
    repeat (3) @(negedge clk);
    check(sb.size() == 0, "R5 full batch retired", 64'(sb.size()), 64'd0);

    // Fault at the head (R6, R7)
    do_alloc(5'd7, 32'hE000_0005, 1'b0);
    do_alloc(5'd8, 32'hE000_0006, 1'b0);
    do_wb(4'd6, 1'b0, pend_val[6]);
    do_wb(4'd5, 1'b1, pend_val[5]);
    repeat (3) @(negedge clk);
    rd_tag[0] = 4'd6;
    #1;
    check(fault_req == 1'b1, "R6 fault raised", {63'd0, fault_req}, 64'd1);
    check(fault_tag == 4'd5, "R6 fault tag", {60'd0, fault_tag}, 64'd5);
    check(commit_valid == 1'b0, "R6 no retire", {63'd0, commit_valid}, 64'd0);
    check(rd_ready[0] == 1'b1, "R9 read behind fault", {63'd0, rd_ready[0]}, 64'd1);
    repeat (5) @(negedge clk);
    #1;
    check(fault_req == 1'b1, "R7 fault held", {63'd0, fault_req}, 64'd1);

    // Flush (R8)
    @(negedge clk);
    flush = 1'b1;
    #1;
    check(alloc_ready == 1'b0, "R8 no alloc during flush", {63'd0, alloc_ready}, 64'd0);
    @(posedge clk);
    #1;
    flush = 1'b0;
    #1;
    check(fault_req == 1'b0, "R8 fault cleared", {63'd0, fault_req}, 64'd0);
    check(commit_valid == 1'b0, "R8 empty", {63'd0, commit_valid}, 64'd0);
    check(alloc_ready == 1'b1, "R8 alloc open", {63'd0, alloc_ready}, 64'd1);
    check(alloc_tag == 4'd7, "R8 tag continues", {60'd0, alloc_tag}, 64'd7);
    check(rd_ready[0] == 1'b0, "R8 slot freed", {63'd0, rd_ready[0]}, 64'd0);

    // Write-back to a free slot is ignored (R3)
    do_wb(4'd9, 1'b0, 32'h0BAD_0BAD);
    do_alloc(5'd10, 32'hF000_0007, 1'b1);
    do_alloc(5'd11, 32'hF000_0008, 1'b1);
    do_alloc(5'd12, 32'hF000_0009, 1'b1);
    @(negedge clk);
    rd_tag[1] = 4'd9;
    #1;
    check(rd_ready[1] == 1'b0, "R3 free-slot write ignored", {63'd0, rd_ready[1]}, 64'd0);
    do_wb(4'd9, 1'b0, pend_val[9]);
    do_wb(4'd7, 1'b0, pend_val[7]);
    do_wb(4'd8, 1'b0, pend_val[8]);
    repeat (5) @(negedge clk);
    check(sb.size() == 0, "R5 final drain", 64'(sb.size()), 64'd0);

    finished = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end
endmodule